// File: doc/BRIEF.md
# Dual-Output Compare Waveform Timer

This block is a single timer channel that produces two pulse outputs, A and B, from one shared up-counter. The counter advances on ticks taken from a prescaled copy of the main clock (divide by 2, 8, 32 or 128) or from rising edges of a slow clock input. Each tick either increments the counter or, when the counter already equals the period register, returns it to zero. The period is therefore shared by both outputs.

Each output is driven only by programmed per-event actions. Output A reacts to a match on its own compare register and to the period match. Output B reacts to a match on a second compare register and to the period match. Both outputs also react to a software trigger, and each action can set, clear or toggle the pin. When every compare action is none, the level left by the last software trigger holds indefinitely. This gives static 0% and 100% outputs. A command register starts and stops the counter clock and issues the software trigger. A build variant replaces the divide-by-2 option with rising edges of an external generic clock.

Top module: `wavetmr`

## Requirements
- R1: After reset both outputs are low, the counter clock is stopped, and the mode, compare-A, compare-B and period registers all read back as zero.
- R2: Register map, with `bus_wr` high for a write and reads returned combinationally for `bus_addr`. 0x00 is mode, 0x04 is compare A, 0x08 is compare B, 0x0C is period, and 0x10 is command, which is write-only and reads as zero. Mode fields are: [2:0] clock select; [5:4] A action on compare-A match; [7:6] A action on period match; [9:8] A action on trigger; [13:12] B action on compare-B match; [15:14] B action on period match; [17:16] B action on trigger. All other mode bits read as zero.
- R3: Clock select 0, 1, 2 and 3 give one tick every 2, 8, 32 and 128 main-clock cycles. Any select with bit 2 set takes one tick per synchronised rising edge of `slow_clk`. With `USE_GEN_CLK`=1, select 0 instead takes one tick per synchronised rising edge of `gen_clk`.
- R4: On each tick the counter increments. If it already equals the period register, it becomes zero instead, so one period lasts period+1 ticks.
- R5: Action codes are 00 none, 01 set, 10 clear and 11 toggle. A match event occurs on a tick in which the counter equals the compare or period value.
- R6: A command write with bit 2 set is a software trigger. It resets the counter and the prescaler phase and applies each output's trigger action in the same edge.
- R7: Command bit 0 starts the counter clock and bit 1 stops it; bit 1 wins when both are set. While the clock is stopped, both outputs hold their level.
- R8: In one cycle, a software trigger takes precedence over a period match, and a period match takes precedence over a compare match.
- R9: With all compare and period actions set to none, each output holds the level from the last software trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_clk | input | 1 | Slow clock, sampled and edge-detected |
| gen_clk | input | 1 | Generic clock for the variant, sampled and edge-detected |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| out_a | output | 1 | Waveform output A |
| out_b | output | 1 | Waveform output B |

## Verification
Pulse trains are measured by counting high cycles over a window that spans a whole number of periods, so the result does not depend on prescaler phase. The patterns are: set-on-period with clear-on-compare at two different duties, toggle-on-period at each divider, on the slow clock and on the generic clock, and compare equal to period. Between them these separate the divide ratios, the wrap point, the action encodings and the period-over-compare precedence. Cycle-exact probes after a software trigger show that the counter restarts from zero, and that a trigger coinciding with a period match wins. Stop and start sequences show that outputs freeze and that stop beats start.

// File: rtl/wavetmr_pkg.sv
package wavetmr_pkg;
  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_SET  = 2'b01,
    ACT_CLR  = 2'b10,
    ACT_TGL  = 2'b11
  } act_e;

  typedef struct packed {
    logic [13:0] rsv_hi;
    act_e        b_trg;
    act_e        b_per;
    act_e        b_cmp;
    logic [1:0]  rsv_mid;
    act_e        a_trg;
    act_e        a_per;
    act_e        a_cmp;
    logic        rsv_lo;
    logic [2:0]  clksel;
  } mode_t;

  localparam logic [31:0] MODE_WMASK = 32'h0003_F3F7;

  localparam logic [4:0] ADR_MODE = 5'h00;
  localparam logic [4:0] ADR_CMPA = 5'h04;
  localparam logic [4:0] ADR_CMPB = 5'h08;
  localparam logic [4:0] ADR_PER  = 5'h0C;
  localparam logic [4:0] ADR_CMD  = 5'h10;

  localparam int CMD_START = 0;
  localparam int CMD_STOP  = 1;
  localparam int CMD_TRIG  = 2;

  function automatic logic act_apply(input act_e a, input logic cur);
    case (a)
      ACT_SET: return 1'b1;
      ACT_CLR: return 1'b0;
      ACT_TGL: return ~cur;
      default: return cur;
    endcase
  endfunction
endpackage

// File: rtl/wt_edge_sync.sv
module wt_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= async_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise = s2_q & ~s3_q;
endmodule

// File: rtl/wt_prescaler.sv
module wt_prescaler #(
  parameter int PRE_W       = 7,
  parameter bit USE_GEN_CLK = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       run,
  input  logic [2:0] sel,
  input  logic       slow_rise,
  input  logic       gen_rise,
  output logic       tick
);
  localparam int N_DIV = 4;

  logic [PRE_W-1:0] pre_q, pre_nx;
  logic [N_DIV-1:0] div_hit;
  logic             raw;

  always_comb begin
    pre_nx = restart ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_nx;
  end

  // Divider d ends on the cycle where its low 2d+1 bits are all ones.
  for (genvar d = 0; d < N_DIV; d++) begin : g_div
    if (d == 0) begin : g_first
      if (USE_GEN_CLK) begin : g_gen
        assign div_hit[d] = gen_rise;
      end else begin : g_pre
        assign div_hit[d] = pre_q[0];
      end
    end else begin : g_rest
      assign div_hit[d] = &pre_q[2*d:0];
    end
  end

  always_comb begin
    raw  = sel[2] ? slow_rise : div_hit[sel[1:0]];
    tick = run & raw;
  end
endmodule

// File: rtl/wt_counter.sv
module wt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clear,
  input  logic [CNT_W-1:0] per,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  output logic [CNT_W-1:0] cnt,
  output logic             hit_per,
  output logic             hit_a,
  output logic             hit_b
);
  logic [CNT_W-1:0] cnt_q, cnt_nx;

  always_comb begin
    hit_per = tick & (cnt_q == per);
    hit_a   = tick & (cnt_q == cmp_a);
    hit_b   = tick & (cnt_q == cmp_b);
    if (clear)        cnt_nx = '0;
    else if (hit_per) cnt_nx = '0;
    else if (tick)    cnt_nx = cnt_q + 1'b1;
    else              cnt_nx = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nx;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/wt_outpin.sv
module wt_outpin
  import wavetmr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic trg,
  input  logic hit_per,
  input  logic hit_cmp,
  input  act_e act_trg,
  input  act_e act_per,
  input  act_e act_cmp,
  output logic pin
);
  logic pin_q, pin_nx;
  act_e act;

  always_comb begin
    if (trg)          act = act_trg;
    else if (hit_per) act = act_per;
    else if (hit_cmp) act = act_cmp;
    else              act = ACT_NONE;
    pin_nx = act_apply(act, pin_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_nx;
  end

  assign pin = pin_q;
endmodule

// File: rtl/wavetmr.sv
module wavetmr
  import wavetmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter bit USE_GEN_CLK = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        slow_clk,
  input  logic        gen_clk,
  input  logic        bus_wr,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        out_a,
  output logic        out_b
);
  localparam int N_OUT = 2;
  localparam int PRE_W = 7;

  mode_t            mode_q;
  logic [CNT_W-1:0] cmpa_q, cmpb_q, per_q, cnt_q;
  logic             run_q, run_nx;
  logic             cmd_wr, trig;
  logic             slow_rise, gen_rise, tick;
  logic             hit_per, hit_a, hit_b;
  logic [N_OUT-1:0] hit_cmp, pins;
  act_e             act_trg [N_OUT];
  act_e             act_per [N_OUT];
  act_e             act_cmp [N_OUT];

  // register file
  always_comb begin
    cmd_wr = bus_wr && (bus_addr == ADR_CMD);
    trig   = cmd_wr & bus_wdata[CMD_TRIG];
    if (cmd_wr && bus_wdata[CMD_STOP])       run_nx = 1'b0;
    else if (cmd_wr && bus_wdata[CMD_START]) run_nx = 1'b1;
    else                                     run_nx = run_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      cmpa_q <= '0;
      cmpb_q <= '0;
      per_q  <= '0;
      run_q  <= 1'b0;
    end else begin
      run_q <= run_nx;
      if (bus_wr && bus_addr == ADR_MODE) mode_q <= mode_t'(bus_wdata & MODE_WMASK);
      if (bus_wr && bus_addr == ADR_CMPA) cmpa_q <= bus_wdata[CNT_W-1:0];
      if (bus_wr && bus_addr == ADR_CMPB) cmpb_q <= bus_wdata[CNT_W-1:0];
      if (bus_wr && bus_addr == ADR_PER)  per_q  <= bus_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    case (bus_addr)
      ADR_MODE: bus_rdata = 32'(mode_q);
      ADR_CMPA: bus_rdata = 32'(cmpa_q);
      ADR_CMPB: bus_rdata = 32'(cmpb_q);
      ADR_PER:  bus_rdata = 32'(per_q);
      default:  bus_rdata = '0;
    endcase
  end

  // tick generation
  wt_edge_sync u_slow_sync (.clk(clk), .rst_n(rst_n), .async_in(slow_clk), .rise(slow_rise));
  wt_edge_sync u_gen_sync  (.clk(clk), .rst_n(rst_n), .async_in(gen_clk),  .rise(gen_rise));

  wt_prescaler #(.PRE_W(PRE_W), .USE_GEN_CLK(USE_GEN_CLK)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(trig), .run(run_q), .sel(mode_q.clksel),
    .slow_rise(slow_rise), .gen_rise(gen_rise), .tick(tick)
  );

  wt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clear(trig), .per(per_q),
    .cmp_a(cmpa_q), .cmp_b(cmpb_q), .cnt(cnt_q),
    .hit_per(hit_per), .hit_a(hit_a), .hit_b(hit_b)
  );

  // output pins
  assign hit_cmp    = {hit_b, hit_a};
  assign act_trg[0] = mode_q.a_trg;
  assign act_per[0] = mode_q.a_per;
  assign act_cmp[0] = mode_q.a_cmp;
  assign act_trg[1] = mode_q.b_trg;
  assign act_per[1] = mode_q.b_per;
  assign act_cmp[1] = mode_q.b_cmp;

  for (genvar g = 0; g < N_OUT; g++) begin : g_pin
    wt_outpin u_pin (
      .clk(clk), .rst_n(rst_n), .trg(trig), .hit_per(hit_per), .hit_cmp(hit_cmp[g]),
      .act_trg(act_trg[g]), .act_per(act_per[g]), .act_cmp(act_cmp[g]), .pin(pins[g])
    );
  end

  assign out_a = pins[0];
  assign out_b = pins[1];
endmodule

// File: rtl/wavetmr_chk.sv
module wavetmr_chk
  import wavetmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [4:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic             out_a,
  input logic             out_b,
  input logic             run_q,
  input logic             tick,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] per_q,
  input mode_t            mode_q
);
  logic cmd_wr, trg_cmd, no_events;

  assign cmd_wr    = bus_wr && (bus_addr == ADR_CMD);
  assign trg_cmd   = cmd_wr && bus_wdata[CMD_TRIG];
  assign no_events = (mode_q.a_cmp == ACT_NONE) && (mode_q.a_per == ACT_NONE) &&
                     (mode_q.b_cmp == ACT_NONE) && (mode_q.b_per == ACT_NONE);

  p_stop_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && bus_wdata[CMD_STOP] |=> !run_q);

  p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q && !trg_cmd |=> $stable(out_a) && $stable(out_b));

  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick && (cnt_q == per_q) && !trg_cmd |=> cnt_q == '0);

  p_trg_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trg_cmd |=> cnt_q == '0);

  p_trg_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trg_cmd && mode_q.a_trg == ACT_CLR && !(bus_wr && bus_addr == ADR_MODE) |=> !out_a);

  p_static_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    no_events && !trg_cmd && !(bus_wr && bus_addr == ADR_MODE)
    |=> $stable(out_a) && $stable(out_b));
endmodule

bind wavetmr wavetmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .out_a(out_a), .out_b(out_b), .run_q(run_q), .tick(tick), .cnt_q(cnt_q),
  .per_q(per_q), .mode_q(mode_q)
);

// File: tb/test_wavetmr.sv
module test_wavetmr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_clk = 1'b0;
  logic        gen_clk = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, rdata_g;
  logic        out_a, out_b, out_a_g, out_b_g;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  initial forever begin
    repeat (10) @(posedge clk);
    slow_clk = ~slow_clk;
  end

  initial forever begin
    repeat (5) @(posedge clk);
    gen_clk = ~gen_clk;
  end

  wavetmr #(.CNT_W(16), .USE_GEN_CLK(1'b0)) i_wavetmr (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .gen_clk(gen_clk),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .out_a(out_a), .out_b(out_b)
  );

  wavetmr #(.CNT_W(16), .USE_GEN_CLK(1'b1)) i_wavetmr_gen (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .gen_clk(gen_clk),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_g),
    .out_a(out_a_g), .out_b(out_b_g)
  );

  localparam logic [1:0] NO = 2'd0, ST = 2'd1, CL = 2'd2, TG = 2'd3;

  function automatic logic [31:0] mk(input logic [2:0] sel,
                                     input logic [1:0] ac, input logic [1:0] ap, input logic [1:0] at,
                                     input logic [1:0] bc, input logic [1:0] bp, input logic [1:0] bt);
    return {14'd0, bt, bp, bc, 2'd0, at, ap, ac, 1'b0, sel};
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic high_count(input int n, input bit use_gen, input bit pin_b, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (use_gen) h += int'(pin_b ? out_b_g : out_a_g);
      else         h += int'(pin_b ? out_b : out_a);
    end
  endtask

  task automatic setup(input logic [31:0] mode, input int ra, input int rb, input int rc);
    wr(5'h00, mode);
    wr(5'h04, 32'(ra));
    wr(5'h08, 32'(rb));
    wr(5'h0C, 32'(rc));
    wr(5'h10, 32'h5);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 out_a after reset", out_a, 0);
    chk("R1 out_b after reset", out_b, 0);
    for (int a = 0; a < 4; a++) begin
      rd(5'(a * 4), d);
      chk("R1 register zero after reset", d, 0);
    end
    high_count(40, 0, 0, a_dummy);
    chk("R1 clock stopped, A stays low", a_dummy, 0);
  endtask
  int a_dummy;

  task automatic t_regs;
    logic [31:0] d;
    wr(5'h00, 32'hFFFF_FFF8);
    rd(5'h00, d); chk("R2 mode reserved bits read zero", d, 32'h0003_F3F0);
    wr(5'h00, 32'h0);
    wr(5'h04, 32'h1234); rd(5'h04, d); chk("R2 compare A readback", d, 32'h1234);
    wr(5'h08, 32'hBEEF); rd(5'h08, d); chk("R2 compare B readback", d, 32'hBEEF);
    wr(5'h0C, 32'h00A5); rd(5'h0C, d); chk("R2 period readback", d, 32'h00A5);
    rd(5'h10, d); chk("R2 command reads zero", d, 0);
  endtask

  task automatic t_static;
    int h;
    setup(mk(3'd0, NO, NO, ST, NO, NO, CL), 1, 1, 3);
    high_count(40, 0, 0, h); chk("R9 A held high (100%)", h, 40);
    high_count(40, 0, 1, h); chk("R9 B held low (0%)", h, 0);
    wr(5'h00, mk(3'd0, NO, NO, CL, NO, NO, ST));
    wr(5'h10, 32'h4);
    high_count(40, 0, 0, h); chk("R9 A held low after trigger", h, 0);
    high_count(40, 0, 1, h); chk("R9 B held high after trigger", h, 40);
  endtask

  task automatic t_pwm_div2;
    int h;
    setup(mk(3'd0, CL, ST, NO, CL, ST, NO), 2, 4, 5);
    repeat (24) @(negedge clk);
    high_count(48, 0, 0, h); chk("R4 R5 A duty 3 of 6 ticks, div2", h, 24);
    high_count(48, 0, 1, h); chk("R4 R5 B duty 5 of 6 ticks, div2", h, 40);
  endtask

  task automatic t_freeze;
    int h;
    logic v;
    wr(5'h10, 32'h2);
    v = out_a;
    high_count(40, 0, 0, h); chk("R7 A frozen after stop", h, v ? 40 : 0);
    wr(5'h10, 32'h3);
    v = out_b;
    high_count(40, 0, 1, h); chk("R7 stop beats start, B frozen", h, v ? 40 : 0);
    wr(5'h10, 32'h1);
    repeat (24) @(negedge clk);
    high_count(48, 0, 0, h); chk("R7 start resumes A waveform", h, 24);
  endtask

  task automatic t_prescale;
    int h;
    setup(mk(3'd1, CL, ST, NO, NO, NO, NO), 1, 0, 3);
    repeat (64) @(negedge clk);
    high_count(128, 0, 0, h); chk("R3 div8 duty 2 of 4 ticks", h, 64);
    setup(mk(3'd2, NO, TG, NO, NO, NO, NO), 0, 0, 1);
    repeat (256) @(negedge clk);
    high_count(256, 0, 0, h); chk("R3 R5 div32 toggle on period", h, 128);
    setup(mk(3'd3, NO, TG, NO, NO, NO, NO), 0, 0, 0);
    repeat (512) @(negedge clk);
    high_count(512, 0, 0, h); chk("R3 div128 toggle every tick", h, 256);
  endtask

  task automatic t_slow_gen;
    int h;
    setup(mk(3'd4, NO, TG, NO, NO, NO, NO), 0, 0, 1);
    repeat (160) @(negedge clk);
    high_count(320, 0, 0, h); chk("R3 slow clock ticks", h, 160);
    setup(mk(3'd0, NO, TG, NO, NO, NO, NO), 0, 0, 1);
    repeat (80) @(negedge clk);
    high_count(160, 1, 0, h); chk("R3 generic clock variant ticks", h, 80);
  endtask

  task automatic t_per_over_cmp;
    int h;
    setup(mk(3'd0, CL, ST, NO, ST, CL, NO), 3, 3, 3);
    repeat (16) @(negedge clk);
    high_count(32, 0, 0, h); chk("R8 period set beats compare clear on A", h, 32);
    high_count(32, 0, 1, h); chk("R8 period clear beats compare set on B", h, 0);
  endtask

  task automatic t_trg_restart;
    wr(5'h00, mk(3'd0, CL, ST, ST, NO, NO, NO));
    wr(5'h04, 32'd2);
    wr(5'h0C, 32'd5);
    wr(5'h10, 32'h5);
    repeat (5) @(negedge clk);
    chk("R6 A still set 5 cycles after trigger", out_a, 1);
    @(negedge clk);
    chk("R6 A cleared at third tick (counter restarted)", out_a, 0);
  endtask

  task automatic t_trg_over_per;
    wr(5'h00, mk(3'd0, NO, ST, CL, NO, NO, NO));
    wr(5'h0C, 32'd0);
    wr(5'h10, 32'h5);
    wr(5'h10, 32'h4);
    chk("R8 trigger clear beats coincident period set", out_a, 0);
    repeat (2) @(negedge clk);
    chk("R5 period set applies on next tick", out_a, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset;
    t_regs;
    t_static;
    t_pwm_div2;
    t_freeze;
    t_prescale;
    t_slow_gen;
    t_per_over_cmp;
    t_trg_restart;
    t_trg_over_per;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule